// File: doc/BRIEF.md
# Key-Protected Clock-Switch Control Register

This block holds the oscillator control word of a chip as two byte lanes behind a byte-wide write port. Software cannot alter either lane with a single store. It must first write that lane's own two-byte key, in order. Only then does the lane take the next byte written to it. The high lane carries the next-oscillator select field and further oscillator settings. The low lane carries the switch request bit and further settings.

The select field and the request bit drive a clock-switch sequencer outside the block. When that sequencer pulses its completion input, the block clears the request. It then copies the select field into the current-oscillator status output. No other bit of either lane changes at that point. A select value of 1 names the internal fast RC oscillator run through the PLL. The block treats the value as an opaque code.

Top module: `oscsw_ctl`

## Requirements
- R1: After reset, and after every committed write, a lane is locked. The high lane (`wr_lane_i` = 1) opens only after the byte 0x78 is written to it and then the byte 0x9A. The next high-lane write after that is stored in `cfg_hi_o`, one clock after the write.
- R2: The low lane (`wr_lane_i` = 0) opens only after the byte 0x46 is written to it and then the byte 0x57. The next low-lane write after that is stored in `cfg_lo_o`.
- R3: A lane write that does not match the expected key returns that lane to locked, and its data is not stored. The first key must then be written again.
- R4: An open lane accepts exactly one write. A further write to that lane without new keys leaves the lane unchanged.
- R5: Writes to one lane neither advance nor break the key sequence of the other lane.
- R6: `nxt_src_o` always equals bits [2:0] of `cfg_hi_o`. The code 1 stands for the fast RC oscillator with the PLL.
- R7: `sw_req_o` is bit 0 of `cfg_lo_o`. It rises only when a committed low-lane write carries a 1 in bit 0.
- R8: When `sw_done_i` is high while `sw_req_o` is high, one clock later `sw_req_o` is 0 and `cur_src_o` holds the select value. Every other bit of both lanes keeps its value. `sw_done_i` has no effect while `sw_req_o` is low.
- R9: While `sw_req_o` is high, a committed low-lane write changes bits [7:1] of the low lane but cannot clear bit 0.
- R10: Reset leaves `cfg_hi_o` = 0x00, `cfg_lo_o` = 0x00, `sw_req_o` = 0 and `cur_src_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Byte write strobe |
| wr_lane_i | input | 1 | Lane select: 1 high, 0 low |
| wr_data_i | input | 8 | Write byte |
| sw_done_i | input | 1 | Sequencer reports the switch finished |
| cfg_hi_o | output | 8 | High lane contents |
| cfg_lo_o | output | 8 | Low lane contents |
| nxt_src_o | output | 3 | Requested oscillator source |
| sw_req_o | output | 1 | Clock-switch request |
| cur_src_o | output | 3 | Current oscillator source |

## Verification
The assertions assume that `sw_done_i` is a single-cycle pulse from a sequencer, and that the write inputs carry known values whenever the strobe is high. The stimulus only ever pulses completion for one cycle. It pulses completion once with no request pending, to show that the block ignores it. Every bench write is a one-cycle strobe. The key sweeps end each trial with a neutral byte, so that every trial starts from a locked lane.

// File: rtl/oscsw_pkg.sv
package oscsw_pkg;
   typedef enum logic [1:0] {
      LK_SHUT = 2'd0,
      LK_HALF = 2'd1,
      LK_OPEN = 2'd2
   } lk_state_e;

   localparam int N_LANES = 2;
   localparam int LANE_LO = 0;
   localparam int LANE_HI = 1;
endpackage

// File: rtl/oscsw_unlock.sv
module oscsw_unlock
   import oscsw_pkg::*;
#(
   parameter int               DATA_W = 8,
   parameter logic [DATA_W-1:0] KEY_A = '0,
   parameter logic [DATA_W-1:0] KEY_B = '1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_i,
   input  logic [DATA_W-1:0] data_i,
   output logic              commit_o
);
   lk_state_e state_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         state_q <= LK_SHUT;
      end else if (wr_i) begin
         case (state_q)
            LK_SHUT: state_q <= (data_i == KEY_A) ? LK_HALF : LK_SHUT;
            LK_HALF: state_q <= (data_i == KEY_B) ? LK_OPEN : LK_SHUT;
            default: state_q <= LK_SHUT;
         endcase
      end
   end

   assign commit_o = wr_i && (state_q == LK_OPEN);

   // R4
   one_shot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      commit_o |=> state_q == LK_SHUT);

   // R1
   open_path_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q == LK_OPEN && $past(state_q) != LK_OPEN) |->
         ($past(state_q) == LK_HALF && $past(wr_i) && $past(data_i) == KEY_B));

   // R3
   half_path_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q == LK_HALF && $past(state_q) != LK_HALF) |->
         ($past(wr_i) && $past(data_i) == KEY_A));
endmodule

// File: rtl/oscsw_regs.sv
module oscsw_regs #(
   parameter int               DATA_W  = 8,
   parameter int               SRC_W   = 3,
   parameter int               REQ_BIT = 0,
   parameter logic [DATA_W-1:0] HI_RST = '0
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              hi_commit_i,
   input  logic              lo_commit_i,
   input  logic [DATA_W-1:0] data_i,
   input  logic              sw_done_i,
   output logic [DATA_W-1:0] hi_q,
   output logic [DATA_W-1:0] lo_q,
   output logic [SRC_W-1:0]  cur_src_q
);
   localparam logic [DATA_W-1:0] REQ_MASK = DATA_W'(1) << REQ_BIT;

   logic              busy;
   logic              finish;
   logic [DATA_W-1:0] lo_d;

   assign busy   = lo_q[REQ_BIT];
   assign finish = busy && sw_done_i;

   always_comb begin
      lo_d = lo_q;
      if (lo_commit_i) begin
         lo_d = data_i;
         if (busy) lo_d[REQ_BIT] = 1'b1;
      end
      if (finish) lo_d[REQ_BIT] = 1'b0;
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         hi_q      <= HI_RST;
         lo_q      <= '0;
         cur_src_q <= HI_RST[SRC_W-1:0];
      end else begin
         if (hi_commit_i) hi_q <= data_i;
         lo_q <= lo_d;
         if (finish) cur_src_q <= hi_q[SRC_W-1:0];
      end
   end

   // R8
   done_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sw_done_i && lo_q[REQ_BIT]) |=> !lo_q[REQ_BIT]);

   // R8
   cur_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sw_done_i && lo_q[REQ_BIT]) |=> cur_src_q == $past(hi_q[SRC_W-1:0]));

   // R8
   keep_other_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sw_done_i && lo_q[REQ_BIT] && !lo_commit_i) |=>
         ((lo_q & ~REQ_MASK) == ($past(lo_q) & ~REQ_MASK)));

   // R8
   cur_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(sw_done_i && lo_q[REQ_BIT]) |=> $stable(cur_src_q));

   // R9
   busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (lo_q[REQ_BIT] && !sw_done_i) |=> lo_q[REQ_BIT]);

   // R7
   req_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(lo_q[REQ_BIT]) |-> $past(lo_commit_i));

   // R3
   hi_guard_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !hi_commit_i |=> $stable(hi_q));

   // R5
   one_lane_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(hi_commit_i && lo_commit_i));
endmodule

// File: rtl/oscsw_ctl.sv
module oscsw_ctl
   import oscsw_pkg::*;
#(
   parameter int               DATA_W   = 8,
   parameter int               SRC_W    = 3,
   parameter int               REQ_BIT  = 0,
   parameter logic [DATA_W-1:0] HI_KEY_A = 8'h78,
   parameter logic [DATA_W-1:0] HI_KEY_B = 8'h9A,
   parameter logic [DATA_W-1:0] LO_KEY_A = 8'h46,
   parameter logic [DATA_W-1:0] LO_KEY_B = 8'h57,
   parameter logic [DATA_W-1:0] HI_RST   = '0
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_en_i,
   input  logic              wr_lane_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic              sw_done_i,
   output logic [DATA_W-1:0] cfg_hi_o,
   output logic [DATA_W-1:0] cfg_lo_o,
   output logic [SRC_W-1:0]  nxt_src_o,
   output logic              sw_req_o,
   output logic [SRC_W-1:0]  cur_src_o
);
   if (SRC_W < 1 || SRC_W > DATA_W) begin : g_bad_src
      $error("oscsw_ctl: SRC_W must lie in 1..DATA_W");
   end
   if (REQ_BIT < 0 || REQ_BIT >= DATA_W) begin : g_bad_req
      $error("oscsw_ctl: REQ_BIT outside the low lane");
   end
   if (HI_KEY_A == HI_KEY_B || LO_KEY_A == LO_KEY_B) begin : g_bad_key
      $error("oscsw_ctl: the two keys of a lane must differ");
   end

   logic [N_LANES-1:0] commit;

   for (genvar l = 0; l < N_LANES; l++) begin : g_lane
      localparam logic [DATA_W-1:0] KA = (l == LANE_HI) ? HI_KEY_A : LO_KEY_A;
      localparam logic [DATA_W-1:0] KB = (l == LANE_HI) ? HI_KEY_B : LO_KEY_B;
      localparam logic              SEL = (l == LANE_HI);

      oscsw_unlock #(
         .DATA_W (DATA_W),
         .KEY_A  (KA),
         .KEY_B  (KB)
      ) u_unlock (
         .clk_i    (clk_i),
         .rst_ni   (rst_ni),
         .wr_i     (wr_en_i && (wr_lane_i == SEL)),
         .data_i   (wr_data_i),
         .commit_o (commit[l])
      );
   end

   oscsw_regs #(
      .DATA_W  (DATA_W),
      .SRC_W   (SRC_W),
      .REQ_BIT (REQ_BIT),
      .HI_RST  (HI_RST)
   ) u_regs (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .hi_commit_i (commit[LANE_HI]),
      .lo_commit_i (commit[LANE_LO]),
      .data_i      (wr_data_i),
      .sw_done_i   (sw_done_i),
      .hi_q        (cfg_hi_o),
      .lo_q        (cfg_lo_o),
      .cur_src_q   (cur_src_o)
   );

   assign nxt_src_o = cfg_hi_o[SRC_W-1:0];
   assign sw_req_o  = cfg_lo_o[REQ_BIT];
endmodule

// File: tb/oscsw_ctl_tb.sv
module oscsw_ctl_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic       wr_lane = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic       sw_done = 1'b0;
   logic [7:0] cfg_hi, cfg_lo;
   logic [2:0] nxt_src, cur_src;
   logic       sw_req;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   logic [7:0] exp_hi = 8'h00;
   logic [7:0] exp_lo = 8'h00;
   logic [7:0] dv;

   always #10 clk = ~clk;

   oscsw_ctl dut_i (
      .clk_i     (clk),
      .rst_ni    (rst_n),
      .wr_en_i   (wr_en),
      .wr_lane_i (wr_lane),
      .wr_data_i (wr_data),
      .sw_done_i (sw_done),
      .cfg_hi_o  (cfg_hi),
      .cfg_lo_o  (cfg_lo),
      .nxt_src_o (nxt_src),
      .sw_req_o  (sw_req),
      .cur_src_o (cur_src)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic lane, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_lane = lane; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic done_pulse();
      @(negedge clk);
      sw_done = 1'b1;
      @(negedge clk);
      sw_done = 1'b0;
   endtask

   function automatic logic [7:0] mix(input logic [7:0] v);
      return {v[2:0], v[7:3]} ^ 8'h3C;
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         checks++; errors++;
         $display("FAIL watchdog act=hung exp=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10 reset state
      chk("R10 hi", cfg_hi, 8'h00);
      chk("R10 lo", cfg_lo, 8'h00);
      chk("R10 req", sw_req, 0);
      chk("R10 cur", cur_src, 0);

      // R1 R3: sweep of the first high key
      for (int v = 0; v < 256; v++) begin
         dv = mix(8'(v));
         wr(1'b1, 8'(v)); wr(1'b1, 8'h9A); wr(1'b1, dv);
         if (8'(v) == 8'h78) exp_hi = dv;
         chk("R1 R3 hi first key", cfg_hi, exp_hi);
         chk("R6 nxt_src", nxt_src, exp_hi[2:0]);
         wr(1'b1, 8'h00);
      end
      // R1 R3: sweep of the second high key
      for (int v = 0; v < 256; v++) begin
         dv = mix(8'(v) ^ 8'h81);
         wr(1'b1, 8'h78); wr(1'b1, 8'(v)); wr(1'b1, dv);
         if (8'(v) == 8'h9A) exp_hi = dv;
         chk("R1 R3 hi second key", cfg_hi, exp_hi);
         wr(1'b1, 8'h00);
      end
      // R2 R3: sweep of the first low key
      for (int v = 0; v < 256; v++) begin
         dv = mix(8'(v)) & 8'hFE;
         wr(1'b0, 8'(v)); wr(1'b0, 8'h57); wr(1'b0, dv);
         if (8'(v) == 8'h46) exp_lo = dv;
         chk("R2 R3 lo first key", cfg_lo, exp_lo);
         chk("R7 req stays low", sw_req, 0);
         wr(1'b0, 8'h00);
      end
      // R2 R3: sweep of the second low key
      for (int v = 0; v < 256; v++) begin
         dv = mix(8'(v) ^ 8'h5A) & 8'hFE;
         wr(1'b0, 8'h46); wr(1'b0, 8'(v)); wr(1'b0, dv);
         if (8'(v) == 8'h57) exp_lo = dv;
         chk("R2 R3 lo second key", cfg_lo, exp_lo);
         wr(1'b0, 8'h00);
      end

      // R4: one write per unlock
      wr(1'b1, 8'h78); wr(1'b1, 8'h9A); wr(1'b1, 8'h5D);
      chk("R4 first write", cfg_hi, 8'h5D);
      wr(1'b1, 8'h22);
      chk("R4 second write ignored", cfg_hi, 8'h5D);

      // R5: interleaved lanes keep their own sequences
      wr(1'b1, 8'h78); wr(1'b0, 8'h46); wr(1'b0, 8'h57);
      wr(1'b1, 8'h9A); wr(1'b1, 8'hA1);
      chk("R5 hi after interleave", cfg_hi, 8'hA1);
      chk("R6 select fast RC with PLL", nxt_src, 3'd1);
      wr(1'b0, 8'h30);
      chk("R5 lo after interleave", cfg_lo, 8'h30);

      // R7 R8: request and completion
      wr(1'b0, 8'h46); wr(1'b0, 8'h57); wr(1'b0, 8'h31);
      chk("R7 req set", sw_req, 1);
      chk("R7 cur before done", cur_src, 0);
      done_pulse();
      chk("R8 req cleared", sw_req, 0);
      chk("R8 cur takes select", cur_src, 1);
      chk("R8 lo others kept", cfg_lo, 8'h30);
      chk("R8 hi kept", cfg_hi, 8'hA1);

      // R8: completion ignored when idle
      wr(1'b1, 8'h78); wr(1'b1, 8'h9A); wr(1'b1, 8'h06);
      done_pulse();
      chk("R8 idle done ignored", cur_src, 1);
      chk("R8 idle done lo", cfg_lo, 8'h30);

      // R9: request bit held during a switch
      wr(1'b0, 8'h46); wr(1'b0, 8'h57); wr(1'b0, 8'hC5);
      chk("R7 req set again", sw_req, 1);
      wr(1'b0, 8'h46); wr(1'b0, 8'h57); wr(1'b0, 8'h0A);
      chk("R9 bit0 held", cfg_lo, 8'h0B);
      chk("R9 req still high", sw_req, 1);
      done_pulse();
      chk("R9 R8 after done lo", cfg_lo, 8'h0A);
      chk("R8 cur second switch", cur_src, 6);

      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule